// File: doc/BRIEF.md
# D-PHY Lane Settle Window Timer

This block sits in the receiver's low-power control clock domain and looks after one clock lane and one data lane. Each lane supplies its low-power line state as a two-bit value. The block passes that value through a two-flop synchroniser. It then watches for the line sequence LP11, LP01, LP00, which asks to enter high-speed mode. When the line reaches LP00, the block raises a mask output for that lane. The mask tells the downstream high-speed receiver to ignore every transition on the lane. After the programmed number of control-clock cycles the mask drops and a high-speed-enable output rises. The enable stays high until the line returns to LP11.

Each lane's window is its programmed settle count plus a fixed offset. The offset is 7 cycles for the clock lane and 5 for the data lane. Both counts are held in one 32-bit control word. Software is expected to choose counts that place the clock-lane window between 95 ns and 300 ns, and the data-lane window between 85 ns + 6 UI and 145 ns + 10 UI. If the line leaves LP00 before the window ends, the lane abandons the entry and gives a one-cycle abort pulse.

Each lane runs its own state machine with these states:
- S_IDLE waits for LP01.
- S_ARMED waits for LP00. It stays in S_ARMED while the line is LP01 and returns to S_IDLE on any other line state.
- S_SETTLE counts the window with the mask high. It goes to S_HS when the count expires, or to S_ABORT if the line leaves LP00.
- S_HS holds the enable high until LP11 returns the lane to S_IDLE.
- S_ABORT lasts one cycle and then returns to S_IDLE.

Top module: `settle_window_timer`

## Requirements
- R1: After reset, cfg_rdata reads 0x0000000A: clock-settle count 0 and data-settle count 10. All mask, enable and abort outputs are low.
- R2: The clock-settle count is written and read in cfg_rdata/cfg_wdata bits 13:8. The data-settle count is in bits 5:0. A write takes effect on the clock edge where cfg_we is high. All other bits read as zero and ignore writes.
- R3: Line state encoding is bit 1 = Dp and bit 0 = Dn, so LP11=2'b11, LP01=2'b01, LP00=2'b00. A lane's mask rises on the third rising clock edge after its input changes from LP01 to LP00, because two edges are spent in the synchroniser.
- R4: The clock-lane mask stays high for exactly (clock-settle count + 7) cycles. Then clk_hs_enable rises in the cycle after the mask falls.
- R5: The data-lane mask stays high for exactly (data-settle count + 5) cycles. Then dat_hs_enable rises in the cycle after the mask falls.
- R6: A lane's enable stays high while the line holds non-LP11 states. It falls on the third rising edge after the input returns to LP11. Mask and enable are never high together.
- R7: A new settle count written while a window is in progress does not change that window. The next entry sequence uses the new count.
- R8: If the line leaves LP00 during the window, the mask drops and abort is high for exactly one cycle. The enable does not rise.
- R9: LP00 reached directly from LP11 without passing through LP01 does not start a window: the mask and enable stay low.
- R10: The two lanes are independent. An entry sequence on one lane leaves the other lane's outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-power control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_lane_lp | input | 2 | Clock lane line state {Dp, Dn} |
| dat_lane_lp | input | 2 | Data lane line state {Dp, Dn} |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read data |
| clk_hs_mask | output | 1 | Ignore HS transitions on clock lane |
| clk_hs_enable | output | 1 | Clock lane HS reception enabled |
| clk_abort | output | 1 | One-cycle pulse, clock lane entry aborted |
| dat_hs_mask | output | 1 | Ignore HS transitions on data lane |
| dat_hs_enable | output | 1 | Data lane HS reception enabled |
| dat_abort | output | 1 | One-cycle pulse, data lane entry aborted |

## Verification
Two events can fall in the same cycle: a control-word write and a running settle count on the lane that the write reprograms. The bench writes new counts to both fields six cycles into an active window on both lanes. It then checks two things: that the current mask lengths still match the old counts, and that the next entry follows the new ones. It also runs entries on both lanes at once with random counts, so that the two windows overlap and expire in different cycles. Each lane's mask length is then compared with its own offset.

// File: rtl/settle_pkg.sv
package settle_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARMED,
        S_SETTLE,
        S_HS,
        S_ABORT
    } lane_state_t;

    // line state codes, bit 1 = Dp, bit 0 = Dn
    localparam logic [1:0] LP11 = 2'b11;
    localparam logic [1:0] LP01 = 2'b01;
    localparam logic [1:0] LP00 = 2'b00;

    localparam int CFG_W = 32;

endpackage

// File: rtl/lp_sync2.sv
module lp_sync2 #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    // resets to all ones so a lane starts in the stop state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q[0] <= '1;
        end else begin
            stage_q[0] <= d;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '1;
            end else begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/settle_cfg.sv
module settle_cfg
    import settle_pkg::*;
#(
    parameter int FIELD_W = 6,
    parameter int CLK_LSB = 8,
    parameter int DAT_LSB = 0,
    parameter int CLK_RST = 0,
    parameter int DAT_RST = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [CFG_W-1:0]   wdata,
    output logic [CFG_W-1:0]   rdata,
    output logic [FIELD_W-1:0] clk_settle,
    output logic [FIELD_W-1:0] dat_settle
);
    logic [FIELD_W-1:0] clk_q;
    logic [FIELD_W-1:0] dat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q <= FIELD_W'(CLK_RST);
            dat_q <= FIELD_W'(DAT_RST);
        end else if (we) begin
            clk_q <= wdata[CLK_LSB +: FIELD_W];
            dat_q <= wdata[DAT_LSB +: FIELD_W];
        end
    end

    always_comb begin
        rdata                       = '0;
        rdata[CLK_LSB +: FIELD_W]   = clk_q;
        rdata[DAT_LSB +: FIELD_W]   = dat_q;
    end

    assign clk_settle = clk_q;
    assign dat_settle = dat_q;

    // R2: a write lands in both fields one edge later
    assert_field_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata[CLK_LSB +: FIELD_W] == $past(wdata[CLK_LSB +: FIELD_W]))
            && (rdata[DAT_LSB +: FIELD_W] == $past(wdata[DAT_LSB +: FIELD_W])));

    // R2: fields hold without a write
    assert_field_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(rdata));

endmodule

// File: rtl/settle_lane.sv
module settle_lane
    import settle_pkg::*;
#(
    parameter int FIELD_W = 6,
    parameter int OFFSET  = 7,
    localparam int CNT_W  = $clog2((1 << FIELD_W) + OFFSET + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         lp,
    input  logic [FIELD_W-1:0] prog,
    output logic               hs_mask,
    output logic               hs_enable,
    output logic               abort
);
    lane_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             load;

    assign load = (state_q == S_ARMED) && (lp == LP00);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (lp == LP01) state_d = S_ARMED;
            S_ARMED: begin
                if (lp == LP00)      state_d = S_SETTLE;
                else if (lp != LP01) state_d = S_IDLE;
            end
            S_SETTLE: begin
                if (lp != LP00)      state_d = S_ABORT;
                else if (cnt_q == '0) state_d = S_HS;
            end
            S_HS:     if (lp == LP11) state_d = S_IDLE;
            S_ABORT:  state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CNT_W'(prog) + CNT_W'(OFFSET - 1);
        end else if (state_q == S_SETTLE && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        hs_mask   = 1'b0;
        hs_enable = 1'b0;
        abort     = 1'b0;
        unique case (state_q)
            S_SETTLE: hs_mask   = 1'b1;
            S_HS:     hs_enable = 1'b1;
            S_ABORT:  abort     = 1'b1;
            default: ;
        endcase
    end

    // checker state: length of the current mask run and the window it should have
    logic [CNT_W:0]   run_q;
    logic [CNT_W-1:0] win_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
            win_q <= '0;
        end else begin
            run_q <= hs_mask ? run_q + 1'b1 : '0;
            if (load) win_q <= CNT_W'(prog) + CNT_W'(OFFSET);
        end
    end

    // R6
    assert_mask_enable_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_mask && hs_enable));

    // R4 (clock lane) and R5 (data lane): enable follows a full window
    assert_window_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_enable) |-> (run_q == (CNT_W+1)'(win_q)));

    assert_enable_after_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_enable) |-> $past(hs_mask));

    // R8
    assert_abort_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !abort);

    assert_abort_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> ($past(hs_mask) && !hs_enable));

    // R9: a window only follows the armed state
    assert_armed_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mask) |-> ($past(state_q) == S_ARMED));

endmodule

// File: rtl/settle_window_timer.sv
module settle_window_timer
    import settle_pkg::*;
#(
    parameter int FIELD_W  = 6,
    parameter int CLK_OFS  = 7,
    parameter int DAT_OFS  = 5,
    parameter int SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        clk_lane_lp,
    input  logic [1:0]        dat_lane_lp,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              clk_hs_mask,
    output logic              clk_hs_enable,
    output logic              clk_abort,
    output logic              dat_hs_mask,
    output logic              dat_hs_enable,
    output logic              dat_abort
);
    logic [1:0]         clk_lp_s, dat_lp_s;
    logic [FIELD_W-1:0] clk_settle, dat_settle;

    settle_cfg #(.FIELD_W(FIELD_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .wdata      (cfg_wdata),
        .rdata      (cfg_rdata),
        .clk_settle (clk_settle),
        .dat_settle (dat_settle)
    );

    lp_sync2 #(.W(2), .STAGES(SYNC_STG)) u_sync_clk (
        .clk (clk), .rst_n (rst_n), .d (clk_lane_lp), .q (clk_lp_s)
    );

    lp_sync2 #(.W(2), .STAGES(SYNC_STG)) u_sync_dat (
        .clk (clk), .rst_n (rst_n), .d (dat_lane_lp), .q (dat_lp_s)
    );

    settle_lane #(.FIELD_W(FIELD_W), .OFFSET(CLK_OFS)) u_clk_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .lp        (clk_lp_s),
        .prog      (clk_settle),
        .hs_mask   (clk_hs_mask),
        .hs_enable (clk_hs_enable),
        .abort     (clk_abort)
    );

    settle_lane #(.FIELD_W(FIELD_W), .OFFSET(DAT_OFS)) u_dat_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .lp        (dat_lp_s),
        .prog      (dat_settle),
        .hs_mask   (dat_hs_mask),
        .hs_enable (dat_hs_enable),
        .abort     (dat_abort)
    );

    // R10: a lane in the stop state keeps its outputs quiet
    assert_lane_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clk_lp_s) == LP11 && clk_lp_s == LP11) |=> !clk_hs_mask && !clk_hs_enable);

endmodule

// File: tb/sim_settle_window_timer.sv
`timescale 1ns/1ps
module sim_settle_window_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  clk_lane_lp = 2'b11;
    logic [1:0]  dat_lane_lp = 2'b11;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        clk_hs_mask, clk_hs_enable, clk_abort;
    logic        dat_hs_mask, dat_hs_enable, dat_abort;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    settle_window_timer u0 (.*);

    function automatic int exp_window(input bit is_clk, input int prog);
        return prog + (is_clk ? 7 : 5);
    endfunction

    function automatic logic [31:0] cfg_word(input int c, input int d);
        return (32'(c & 63) << 8) | 32'(d & 63);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // runs an entry on the chosen lanes; counts mask cycles, abort pulses and the mask start
    task automatic entry(input bit use_c, input bit use_d, input bit mid_wr,
                         input logic [31:0] mid_word,
                         output int cm, output int dm, output int first_c,
                         output bit ce, output bit de, output int ab);
        cm = 0; dm = 0; first_c = -1; ab = 0;
        @(negedge clk);
        if (use_c) clk_lane_lp = 2'b01;
        if (use_d) dat_lane_lp = 2'b01;
        repeat (4) @(negedge clk);
        if (use_c) clk_lane_lp = 2'b00;
        if (use_d) dat_lane_lp = 2'b00;
        for (int i = 0; i < 90; i++) begin
            if (mid_wr && i == 6) begin cfg_we = 1'b1; cfg_wdata = mid_word; end
            @(negedge clk);
            if (mid_wr && i == 6) cfg_we = 1'b0;
            if (clk_hs_mask) begin cm++; if (first_c < 0) first_c = i; end
            if (dat_hs_mask) dm++;
            if (clk_abort || dat_abort) ab++;
        end
        ce = clk_hs_enable; de = dat_hs_enable;
    endtask

    task automatic to_stop(output bit ce_gone_early, output bit ce_after, output bit de_after);
        @(negedge clk);
        clk_lane_lp = 2'b11; dat_lane_lp = 2'b11;
        @(negedge clk); @(negedge clk);
        ce_gone_early = !(clk_hs_enable || dat_hs_enable);
        @(negedge clk);
        ce_after = clk_hs_enable; de_after = dat_hs_enable;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int cm, dm, fc, ab;
        bit ce, de, early, ca, da;
        int pc, pd;
        void'($urandom(32'd1234));

        repeat (3) @(negedge clk);
        // R1 reset state
        check(cfg_rdata == 32'h0000000A, "R1 rdata", int'(cfg_rdata), 10);
        check(!clk_hs_mask && !clk_hs_enable && !clk_abort && !dat_hs_mask
              && !dat_hs_enable && !dat_abort, "R1 outputs", 1, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 field placement, unused bits ignored
        write_cfg(32'hFFFF_FFFF);
        check(cfg_rdata == 32'h0000_3F3F, "R2 mask bits", int'(cfg_rdata), 32'h3F3F);
        write_cfg(cfg_word(12, 3));
        check(cfg_rdata == 32'h0000_0C03, "R2 fields", int'(cfg_rdata), 32'h0C03);

        // R3/R4/R5 directed, both lanes together (overlapping windows)
        entry(1, 1, 0, 0, cm, dm, fc, ce, de, ab);
        check(fc == 2, "R3 mask start", fc, 2);
        check(cm == exp_window(1, 12), "R4 clock window", cm, exp_window(1, 12));
        check(dm == exp_window(0, 3), "R5 data window", dm, exp_window(0, 3));
        check(ce && de, "R6 enables held", int'(ce) + int'(de), 2);
        // R6: enables hold through a non-stop state, drop after LP11
        @(negedge clk); clk_lane_lp = 2'b10;
        repeat (4) @(negedge clk);
        check(clk_hs_enable, "R6 hold on LP10", int'(clk_hs_enable), 1);
        to_stop(early, ca, da);
        check(!early, "R6 no early drop", int'(early), 0);
        check(!ca && !da, "R6 drop after LP11", int'(ca) + int'(da), 0);

        // R4/R5 boundary counts
        write_cfg(cfg_word(0, 63));
        entry(1, 1, 0, 0, cm, dm, fc, ce, de, ab);
        check(cm == 7, "R4 zero count", cm, 7);
        check(dm == 68, "R5 max count", dm, 68);
        to_stop(early, ca, da);
        write_cfg(cfg_word(63, 0));
        entry(1, 1, 0, 0, cm, dm, fc, ce, de, ab);
        check(cm == 70, "R4 max count", cm, 70);
        check(dm == 5, "R5 zero count", dm, 5);
        to_stop(early, ca, da);

        // R7 write during the window
        write_cfg(cfg_word(20, 20));
        entry(1, 1, 1, cfg_word(2, 9), cm, dm, fc, ce, de, ab);
        check(cm == exp_window(1, 20), "R7 clock current", cm, exp_window(1, 20));
        check(dm == exp_window(0, 20), "R7 data current", dm, exp_window(0, 20));
        to_stop(early, ca, da);
        entry(1, 1, 0, 0, cm, dm, fc, ce, de, ab);
        check(cm == exp_window(1, 2), "R7 clock next", cm, exp_window(1, 2));
        check(dm == exp_window(0, 9), "R7 data next", dm, exp_window(0, 9));
        to_stop(early, ca, da);

        // R10 lanes independent
        entry(0, 1, 0, 0, cm, dm, fc, ce, de, ab);
        check(cm == 0 && !ce, "R10 clock quiet", cm, 0);
        check(dm == exp_window(0, 9) && de, "R10 data alone", dm, exp_window(0, 9));
        to_stop(early, ca, da);

        // R9 LP11 straight to LP00
        @(negedge clk); clk_lane_lp = 2'b00; dat_lane_lp = 2'b00;
        cm = 0; dm = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (clk_hs_mask || clk_hs_enable) cm++;
            if (dat_hs_mask || dat_hs_enable) dm++;
        end
        check(cm == 0 && dm == 0, "R9 no window", cm + dm, 0);
        to_stop(early, ca, da);

        // R8 abort in the window
        write_cfg(cfg_word(10, 10));
        @(negedge clk); clk_lane_lp = 2'b01; dat_lane_lp = 2'b01;
        repeat (4) @(negedge clk);
        clk_lane_lp = 2'b00; dat_lane_lp = 2'b00;
        repeat (5) @(negedge clk);
        clk_lane_lp = 2'b10; dat_lane_lp = 2'b01;
        ab = 0; cm = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (clk_abort) ab++;
            if (dat_abort) ab++;
            if (clk_hs_enable || dat_hs_enable) cm++;
        end
        check(ab == 2, "R8 abort pulses", ab, 2);
        check(cm == 0, "R8 no enable", cm, 0);
        check(!clk_hs_mask && !dat_hs_mask, "R8 mask low", int'(clk_hs_mask), 0);
        to_stop(early, ca, da);

        // random counts on both lanes, R4 and R5
        for (int k = 0; k < 6; k++) begin
            pc = int'($urandom_range(63, 0));
            pd = int'($urandom_range(63, 0));
            write_cfg(cfg_word(pc, pd) | (32'($urandom) & 32'hFFFF_C0C0));
            entry(1, 1, 0, 0, cm, dm, fc, ce, de, ab);
            check(cm == exp_window(1, pc) && ce, "R4 random", cm, exp_window(1, pc));
            check(dm == exp_window(0, pd) && de, "R5 random", dm, exp_window(0, pd));
            check(ab == 0, "R8 no abort on clean entry", ab, 0);
            to_stop(early, ca, da);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule